// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether a received frame that carries a group (multicast) destination address should be kept. It holds a 4096-bit table and treats one bit as a yes or no for every possible 12-bit hash. The hash needs no arithmetic. It is a direct pick of twelve adjacent bits of the 48-bit destination address. A two-bit window mode says which twelve bits are picked.

Software sees the table as 128 words of 32 bits through a simple register port. It also sees the mode as one more register location on the same port. To enable a group address, software reads the word that holds the hash bit, ORs the bit in and writes the word back. A single-cycle clear pulse empties the whole table at once. The receive path presents each destination address with a strobe, and the block answers with a registered match flag one clock later.

The address is given as 48 bits with byte k at bits 8k+7:8k. Byte 0 is the first byte on the wire, so the group bit is bit 0 of the vector.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset, every table word and the mode register read back as zero, and `match_o` is low.
- R2: A write on the register port to a location 0 to 127 replaces that whole table word. A later read of that location returns the written value.
- R3: Location 128 holds the window mode in bits 1:0 and reads back with bits 31:2 zero. Writes to locations 129 to 255 change neither the table nor the mode, and reads there return zero.
- R4: In mode 0 the hash is destination address bits 47:36.
- R5: In mode 1 the hash is destination address bits 46:35.
- R6: In mode 2 the hash is destination address bits 45:34.
- R7: In mode 3 the hash is destination address bits 43:32.
- R8: Hash bits 11:5 choose the table word and hash bits 4:0 choose the bit inside that word. Address bits outside the selected window have no effect on the result.
- R9: `match_o` can only be high when a strobe was given and address bit 0 (the group bit) was one. A strobe with bit 0 clear, or no strobe, gives a low `match_o`.
- R10: `match_o` reflects the strobe of the previous clock cycle only. It is high for exactly the cycle after a matching strobe.
- R11: A table or mode write in the same cycle as a strobe does not affect that lookup. The new contents apply from the next cycle on.
- R12: A clear pulse sets all 128 table words to zero for the next cycle and wins over a table write in the same cycle. It leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all | input | 1 | One-cycle pulse that empties the table |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 8 | Register location: 0-127 table words, 128 mode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the location on `reg_addr` (combinational) |
| lkp_valid | input | 1 | Destination address strobe |
| lkp_mac | input | 48 | Destination address, byte k at bits 8k+7:8k |
| match_o | output | 1 | Lookup result, one cycle after the strobe |

## Verification
Each mode is first tried with an address that has a known hash and a single set table bit. Random noise is put in the bits outside the window, and the expected result stays high. Flipping the top window bit must then clear it, which shows that the window sits in the right place for that mode. A long random phase mixes random table contents, modes and addresses, with the group bit set about half the time. This phase tests the word and bit split of the hash and the unicast gating. Directed cases cover the collisions that a purely random run seldom hits: a write and a lookup in the same cycle, a clear together with a write, and writes above the mode location.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int unsigned MAC_W   = 48;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned N_MODES = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    WIN_47_36 = 2'd0,
    WIN_46_35 = 2'd1,
    WIN_45_34 = 2'd2,
    WIN_43_32 = 2'd3
  } win_mode_e;

  // lowest address bit of the hash window for each mode
  function automatic int unsigned win_low(int unsigned m);
    case (m)
      0:       win_low = 36;
      1:       win_low = 35;
      2:       win_low = 34;
      default: win_low = 32;
    endcase
  endfunction

endpackage

// File: rtl/mhf_index_pick.sv
module mhf_index_pick
  import mhf_pkg::*;
#(
  parameter int unsigned IDX_W = 12
) (
  input  logic [MAC_W-1:0] mac_i,
  input  win_mode_e        mode_i,
  output logic [IDX_W-1:0] idx_o
);

  logic [IDX_W-1:0] cand [N_MODES];

  for (genvar m = 0; m < N_MODES; m++) begin : g_win
    localparam int unsigned LO = win_low(m);
    assign cand[m] = mac_i[LO +: IDX_W];
  end

  assign idx_o = cand[mode_i];

endmodule

// File: rtl/mhf_bit_table.sv
module mhf_bit_table #(
  parameter  int unsigned WORD_W  = 32,
  parameter  int unsigned N_WORDS = 128,
  localparam int unsigned SEL_W   = $clog2(N_WORDS),
  localparam int unsigned OFF_W   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic [SEL_W-1:0]  lk_sel_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  output logic              lk_bit_o
);

  logic [WORD_W-1:0] mem_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic              we;
    logic [WORD_W-1:0] word_d;

    always_comb begin
      we     = clr_i | (wr_en_i && (wr_sel_i == SEL_W'(w)));
      word_d = clr_i ? '0 : wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[w] <= '0;
      end else if (we) begin
        mem_q[w] <= word_d;
      end
    end
  end

  logic [WORD_W-1:0] lk_word;

  always_comb begin
    rd_data_o = mem_q[rd_sel_i];
    lk_word   = mem_q[lk_sel_i];
    lk_bit_o  = lk_word[lk_off_i];
  end

endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
  import mhf_pkg::*;
#(
  parameter  int unsigned IDX_W   = 12,
  parameter  int unsigned WORD_W  = 32,
  localparam int unsigned N_WORDS = (1 << IDX_W) / WORD_W,
  localparam int unsigned OFF_W   = $clog2(WORD_W),
  localparam int unsigned SEL_W   = IDX_W - OFF_W,
  localparam int unsigned RA_W    = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              lkp_valid,
  input  logic [MAC_W-1:0]  lkp_mac,
  output logic              match_o
);

  localparam logic [RA_W-1:0] CTRL_ADDR = RA_W'(N_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  // register port decode
  logic      tbl_we;
  logic      mode_we;
  win_mode_e mode_q;
  win_mode_e mode_d;

  always_comb begin
    tbl_we  = reg_wr && !reg_addr[SEL_W];
    mode_we = reg_wr && (reg_addr == CTRL_ADDR);
    mode_d  = win_mode_e'(reg_wdata[MODE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= WIN_47_36;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  // hash window selection
  logic [IDX_W-1:0] idx;

  mhf_index_pick #(.IDX_W(IDX_W)) u_pick (
    .mac_i  (lkp_mac),
    .mode_i (mode_q),
    .idx_o  (idx)
  );

  // table storage
  logic [WORD_W-1:0] tbl_rdata;
  logic              hit_bit;

  mhf_bit_table #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_table (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr_i     (clr_all),
    .wr_en_i   (tbl_we),
    .wr_sel_i  (reg_addr[SEL_W-1:0]),
    .wr_data_i (reg_wdata),
    .rd_sel_i  (reg_addr[SEL_W-1:0]),
    .rd_data_o (tbl_rdata),
    .lk_sel_i  (idx[IDX_W-1:OFF_W]),
    .lk_off_i  (idx[OFF_W-1:0]),
    .lk_bit_o  (hit_bit)
  );

  always_comb begin
    if (!reg_addr[SEL_W]) begin
      reg_rdata = tbl_rdata;
    end else if (reg_addr == CTRL_ADDR) begin
      reg_rdata = WORD_W'(mode_q);
    end else begin
      reg_rdata = '0;
    end
  end

  // registered lookup result
  logic match_d;

  always_comb begin
    match_d = lkp_valid && lkp_mac[0] && hit_bit;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      match_o <= 1'b0;
    end else begin
      match_o <= match_d;
    end
  end

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned RA_W   = 8,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_all,
  input logic              reg_wr,
  input logic [RA_W-1:0]   reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              lkp_valid,
  input logic              lkp_grp,
  input logic [1:0]        mode_q,
  input logic              match_o
);

  localparam logic [RA_W-1:0] CTRL_ADDR = {1'b1, {(RA_W-1){1'b0}}};

  p_no_strobe_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !match_o);

  p_unicast_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !lkp_grp) |=> !match_o);

  p_mode_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CTRL_ADDR) |=> (mode_q == $past(reg_wdata[1:0])));

  p_high_addr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr > CTRL_ADDR) |=> $stable(mode_q));

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (reg_addr[RA_W-1] || reg_rdata == '0));

  p_word_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr[RA_W-1] && !clr_all) |=>
      ((reg_addr != $past(reg_addr)) || reg_rdata == $past(reg_wdata)));

endmodule

bind mc_hash_filter mhf_checker #(.RA_W(RA_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .clr_all   (clr_all),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .lkp_valid (lkp_valid),
  .lkp_grp   (lkp_mac[0]),
  .mode_q    (mode_q),
  .match_o   (match_o)
);

// File: tb/mc_hash_filter_tb_top.sv
module mc_hash_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_all;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lkp_valid;
  logic [47:0] lkp_mac;
  logic        match_o;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  logic [31:0] mdl [128];
  logic [1:0]  mdl_mode;

  always #5 clk = ~clk;

  mc_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lkp_valid(lkp_valid), .lkp_mac(lkp_mac), .match_o(match_o)
  );

  function automatic int unsigned lo_of(logic [1:0] m);
    case (m)
      2'd0: return 36;
      2'd1: return 35;
      2'd2: return 34;
      default: return 32;
    endcase
  endfunction

  function automatic logic exp_match(logic v, logic [47:0] mac);
    logic [11:0] h;
    h = 12'((mac >> lo_of(mdl_mode)) & 48'hFFF);
    return v && mac[0] && mdl[h[11:5]][h[4:0]];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs are driven while clk is low; step moves to the next low phase
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; clr_all = 0; lkp_valid = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a < 8'd128) mdl[a[6:0]] = d;
    else if (a == 8'd128) mdl_mode = d[1:0];
    step();
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic look(string req, logic v, logic [47:0] mac);
    logic e;
    e = exp_match(v, mac);
    lkp_valid = v; lkp_mac = mac;
    step();
    chk(req, 32'(match_o), 32'(e));
  endtask

  task automatic clear();
    clr_all = 1;
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    step();
  endtask

  initial begin
    string names [4];
    logic [47:0] mac;
    logic [11:0] hv;
    int unsigned lo;
    names[0] = "R4"; names[1] = "R5"; names[2] = "R6"; names[3] = "R7";
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    mdl_mode = 0;
    rst_n = 0; clr_all = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    lkp_valid = 0; lkp_mac = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", 32'(match_o), 0);
    rd_chk("R1", 8'd0, 0);
    rd_chk("R1", 8'd77, 0);
    rd_chk("R1", 8'd127, 0);
    rd_chk("R1", 8'd128, 0);

    // R2 word write and readback
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 127));
      wr(a, $urandom());
      rd_chk("R2", a, mdl[a[6:0]]);
    end
    wr(8'd127, 32'hDEADBEEF);
    rd_chk("R2", 8'd127, 32'hDEADBEEF);

    // R3 mode register and ignored high locations
    wr(8'd128, 32'hFFFF_FFFE);
    rd_chk("R3", 8'd128, 32'd2);
    reg_wr = 1; reg_addr = 8'd200; reg_wdata = 32'h1; step();
    rd_chk("R3", 8'd128, 32'd2);
    rd_chk("R3", 8'd200, 0);
    reg_wr = 1; reg_addr = 8'd129; reg_wdata = 32'hFFFF_FFFF; step();
    rd_chk("R3", 8'd1, mdl[1]);
    rd_chk("R3", 8'd128, 32'd2);

    // R4..R7 directed window placement
    for (int m = 0; m < 4; m++) begin
      logic [47:0] noise;
      clear();
      wr(8'd128, 32'(m));
      lo = lo_of(2'(m));
      hv = 12'hA5C;
      wr({1'b0, hv[11:5]}, 32'h1 << hv[4:0]);
      mac = (48'(hv) << lo) | 48'h1;
      noise = 48'($urandom()) & ~(48'hFFF << lo);
      look(names[m], 1, mac | noise);
      chk(names[m], 32'(match_o), 1);
      look(names[m], 1, mac ^ (48'h1 << (lo + 11)));
      chk(names[m], 32'(match_o), 0);
    end

    // R10 result only for the cycle after the strobe
    look("R10", 1, mac);
    chk("R10", 32'(match_o), 1);
    step();
    chk("R10", 32'(match_o), 0);

    // R9 unicast address with the hash bit set
    look("R9", 1, mac & ~48'h1);
    chk("R9", 32'(match_o), 0);

    // R8 random table, modes and addresses
    for (int i = 0; i < 128; i++) wr(8'(i), $urandom() & $urandom());
    for (int k = 0; k < 400; k++) begin
      if (k % 100 == 0) wr(8'd128, 32'($urandom_range(0, 3)));
      mac = {$urandom(), $urandom()};
      mac[0] = $urandom_range(0, 1) != 0;
      look("R8", $urandom_range(0, 7) != 0, mac);
    end

    // R11 write in the same cycle as the lookup
    wr(8'd128, 32'd3);
    hv = 12'h3C1;
    wr({1'b0, hv[11:5]}, 32'h0);
    mac = (48'(hv) << 32) | 48'h1;
    lkp_valid = 1; lkp_mac = mac;
    reg_wr = 1; reg_addr = {1'b0, hv[11:5]}; reg_wdata = 32'h1 << hv[4:0];
    mdl[hv[11:5]] = reg_wdata;
    step();
    chk("R11", 32'(match_o), 0);
    look("R11", 1, mac);
    chk("R11", 32'(match_o), 1);
    // mode change in the same cycle as a lookup
    lkp_valid = 1; lkp_mac = mac;
    reg_wr = 1; reg_addr = 8'd128; reg_wdata = 32'd0;
    step();
    mdl_mode = 0;
    chk("R11", 32'(match_o), 1);

    // R12 clear wins over a same-cycle write, mode kept
    clr_all = 1; reg_wr = 1; reg_addr = 8'd3; reg_wdata = 32'hFFFF_FFFF;
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    step();
    for (int i = 0; i < 128; i++) rd_chk("R12", 8'(i), 0);
    rd_chk("R12", 8'd128, 0);
    wr(8'd128, 32'd3);
    look("R12", 1, mac);
    chk("R12", 32'(match_o), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule